// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block generates the vertical timing of a display pipe whose frame length may vary from one frame to the next. It counts scanlines on a line-tick pulse and reports the current line number. It raises vertical blank once the active region ends. In variable refresh mode the blank is held open for as long as a minimum and a maximum frame length allow. Software ends a stretched blank early by posting a push request through a small register port. The block then starts the exit sequence at the first legal line. The exit sequence runs for a fixed number of lines and ends in a frame-start strobe.

Three values are derived from the registers. The exit length is the guardband, plus the frame-start delay, plus one mandatory line. The earliest exit line is the flipline length minus the exit length. The latest exit line is the maximum length minus the exit length. A latch strobe marks the line on which the exit begins, and shadowed timing registers elsewhere in the pipe take their new values on that strobe. With variable refresh off, the frame has a fixed total and the latch strobe falls on the first blank line.

Register map (word addresses): 0 minimum length, 1 maximum length, 2 flipline length, 3 control, 4 push. Each length register holds the desired line count minus one. Control bit 0 enables variable refresh and bit 1 enables the flipline register. Bits [3:2] hold the frame-start delay minus one, and bits [15:8] hold the guardband. Push bit 0 is the enable, and bit 1 is send on write and pending on read.

Top module: `vrr_vtiming`

## Requirements
- R1: After reset the line number is 0, both strobes are low and the push register reads 0.
- R2: A length register reads back exactly the value written, and the line count it sets is that value plus one.
- R3: With control bit 0 clear, the frame total is the minimum register plus one, and the latch strobe pulses on the tick that moves the line number to the active height.
- R4: vblank is low while the line number is below the active height and high from the active height until the frame wraps.
- R5: With variable refresh on and no push, the exit begins (latch strobe) on line vmax+1−E and the frame total is vmax+1, where E = guardband + (delay code+1) + 1.
- R6: A push written while the line number is inside the exit window starts the exit on the next line tick, so the frame total is that line + E.
- R7: A push written before the earliest line is held, and the exit begins exactly on the earliest line (flipline+1−E).
- R8: Changing the guardband or the delay code changes both exit lines by the change in E.
- R9: The send bit is stored only when written with the enable bit (data 3). Push reads bit 1 as pending, and pending clears when the exit consumes it.
- R10: The frame-start strobe is a one-cycle pulse on the tick where the line number wraps to 0.
- R11: With control bit 1 clear, the earliest line uses the minimum register plus two in place of the flipline length.
- R12: Writing 0 to control and push returns the block to fixed-total timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Register read data (combinational) |
| active_h | input | LINE_W | Active display height in lines |
| vblank | output | 1 | Vertical blank indicator |
| latch_stb | output | 1 | Register-latch strobe at exit start |
| fstart_stb | output | 1 | Frame-start strobe at line wrap |
| line_num | output | LINE_W | Current scanline number |

## Verification
The hardest case to reach is a push request that lands inside the exit window on a known line. The request has to arrive between two line ticks and must not be consumed by an earlier frame. The bench first runs ticks until a frame-start strobe aligns it to line 0. It then counts ticks and writes the push right after the tick that reaches the chosen line. The latch line and the frame total then follow exactly from the register values. A held early push is produced the same way, by writing it just after frame start, well before the earliest line.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
   // register word addresses
   localparam int ADDR_VMIN  = 0;
   localparam int ADDR_VMAX  = 1;
   localparam int ADDR_FLIP  = 2;
   localparam int ADDR_CTRL  = 3;
   localparam int ADDR_PUSH  = 4;
   // control word fields
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_FLIP_BIT = 1;
   localparam int CTRL_FSD_LSB  = 2;
   localparam int CTRL_FSD_W    = 2;
   localparam int CTRL_GB_LSB   = 8;
   // push word fields
   localparam int PUSH_EN_BIT   = 0;
   localparam int PUSH_SEND_BIT = 1;
endpackage

// File: rtl/vrr_regs.sv
module vrr_regs
   import vrr_pkg::*;
#(
   parameter int LINE_W = 13,
   parameter int REG_W  = 16,
   parameter int ADDR_W = 3,
   parameter int GB_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [REG_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [REG_W-1:0]      rd_data,
   input  logic                  consume,
   output logic [LINE_W-1:0]     vmin_raw,
   output logic [LINE_W-1:0]     vmax_raw,
   output logic [LINE_W-1:0]     flip_raw,
   output logic                  vrr_on,
   output logic                  flip_en,
   output logic [CTRL_FSD_W-1:0] fsd_code,
   output logic [GB_W-1:0]       guard,
   output logic                  pend
);
   logic [REG_W-1:0] vmin_q, vmax_q, flip_q, ctrl_q;
   logic             push_en_q, pend_q;
   logic             wr_push;

   assign wr_push = wr_en && (wr_addr == ADDR_W'(ADDR_PUSH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vmin_q    <= '0;
         vmax_q    <= '0;
         flip_q    <= '0;
         ctrl_q    <= '0;
         push_en_q <= 1'b0;
         pend_q    <= 1'b0;
      end else begin
         if (consume) pend_q <= 1'b0;
         if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_VMIN)) vmin_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_VMAX)) vmax_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_FLIP)) flip_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_CTRL)) ctrl_q <= wr_data;
         end
         if (wr_push) begin
            push_en_q <= wr_data[PUSH_EN_BIT];
            pend_q    <= wr_data[PUSH_EN_BIT] & wr_data[PUSH_SEND_BIT];
         end
      end
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(ADDR_VMIN): rd_data = vmin_q;
         ADDR_W'(ADDR_VMAX): rd_data = vmax_q;
         ADDR_W'(ADDR_FLIP): rd_data = flip_q;
         ADDR_W'(ADDR_CTRL): rd_data = ctrl_q;
         ADDR_W'(ADDR_PUSH): rd_data = REG_W'({pend_q, push_en_q});
         default:            rd_data = '0;
      endcase
   end

   assign vmin_raw = vmin_q[LINE_W-1:0];
   assign vmax_raw = vmax_q[LINE_W-1:0];
   assign flip_raw = flip_q[LINE_W-1:0];
   assign vrr_on   = ctrl_q[CTRL_EN_BIT];
   assign flip_en  = ctrl_q[CTRL_FLIP_BIT];
   assign fsd_code = ctrl_q[CTRL_FSD_LSB +: CTRL_FSD_W];
   assign guard    = ctrl_q[CTRL_GB_LSB +: GB_W];
   assign pend     = pend_q;

   // R9
   push_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !wr_push) |=> !pend_q);
endmodule

// File: rtl/vrr_window.sv
module vrr_window
   import vrr_pkg::*;
#(
   parameter int LINE_W = 13,
   parameter int GB_W   = 8,
   parameter bit CLAMP  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINE_W-1:0]     vmin_raw,
   input  logic [LINE_W-1:0]     vmax_raw,
   input  logic [LINE_W-1:0]     flip_raw,
   input  logic                  flip_en,
   input  logic [CTRL_FSD_W-1:0] fsd_code,
   input  logic [GB_W-1:0]       guard,
   output logic [LINE_W-1:0]     earliest,
   output logic [LINE_W-1:0]     latest,
   output logic [LINE_W-1:0]     exit_len,
   output logic [LINE_W:0]       fixed_total
);
   localparam int CW = LINE_W + 2;

   logic [CW-1:0] exit_c, flip_c, vmax_c, early_c, late_c;
   logic [LINE_W-1:0] early_d, late_d;

   // exit length = guardband + (code+1) + 1 mandatory line
   assign exit_c  = CW'(guard) + CW'(fsd_code) + CW'(2);
   assign flip_c  = flip_en ? CW'(flip_raw) + CW'(1) : CW'(vmin_raw) + CW'(2);
   assign vmax_c  = CW'(vmax_raw) + CW'(1);
   assign early_c = flip_c - exit_c;
   assign late_c  = vmax_c - exit_c;

   generate
      if (CLAMP) begin : g_clamp
         assign early_d = early_c[CW-1] ? '0 : early_c[LINE_W-1:0];
         assign late_d  = late_c[CW-1]  ? '0 : late_c[LINE_W-1:0];
      end else begin : g_wrap
         assign early_d = early_c[LINE_W-1:0];
         assign late_d  = late_c[LINE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         earliest    <= '0;
         latest      <= '0;
         exit_len    <= '0;
         fixed_total <= '0;
      end else begin
         earliest    <= early_d;
         latest      <= late_d;
         exit_len    <= exit_c[LINE_W-1:0];
         fixed_total <= {1'b0, vmin_raw} + {{LINE_W{1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/vrr_linegen.sv
module vrr_linegen #(
   parameter int LINE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              vrr_on,
   input  logic              pend,
   input  logic [LINE_W-1:0] active_h,
   input  logic [LINE_W-1:0] earliest,
   input  logic [LINE_W-1:0] latest,
   input  logic [LINE_W-1:0] exit_len,
   input  logic [LINE_W:0]   fixed_total,
   output logic              consume,
   output logic [LINE_W-1:0] line_num,
   output logic              vblank,
   output logic              latch_stb,
   output logic              fstart_stb
);
   logic [LINE_W-1:0] line_q, rem_q;
   logic              exit_q, latch_q, fs_q;
   logic [LINE_W:0]   nxt;
   logic              start;

   assign nxt   = {1'b0, line_q} + {{LINE_W{1'b0}}, 1'b1};
   assign start = (nxt >= {1'b0, latest}) || (pend && (nxt >= {1'b0, earliest}));
   assign consume = line_tick && vrr_on && !exit_q && start && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         rem_q   <= '0;
         exit_q  <= 1'b0;
         latch_q <= 1'b0;
         fs_q    <= 1'b0;
      end else begin
         latch_q <= 1'b0;
         fs_q    <= 1'b0;
         if (line_tick) begin
            if (!vrr_on) begin
               exit_q <= 1'b0;
               if (nxt >= fixed_total) begin
                  line_q <= '0;
                  fs_q   <= 1'b1;
               end else begin
                  line_q  <= nxt[LINE_W-1:0];
                  latch_q <= (nxt == {1'b0, active_h});
               end
            end else if (exit_q) begin
               if (rem_q == '0) begin
                  line_q <= '0;
                  exit_q <= 1'b0;
                  fs_q   <= 1'b1;
               end else begin
                  line_q <= nxt[LINE_W-1:0];
                  rem_q  <= rem_q - 1'b1;
               end
            end else begin
               line_q <= nxt[LINE_W-1:0];
               if (start) begin
                  exit_q  <= 1'b1;
                  rem_q   <= exit_len - 1'b1;
                  latch_q <= 1'b1;
               end
            end
         end
      end
   end

   assign line_num   = line_q;
   assign vblank     = (line_q >= active_h);
   assign latch_stb  = latch_q;
   assign fstart_stb = fs_q;

   // R10
   fstart_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fstart_stb |-> (line_num == '0));
   // R3
   latch_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |-> vblank);
   // R5
   exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && vrr_on && exit_q && rem_q != '0) |=> (exit_q && !fstart_stb));
endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming
   import vrr_pkg::*;
#(
   parameter int LINE_W       = 13,
   parameter int REG_W        = 16,
   parameter int ADDR_W       = 3,
   parameter int GB_W         = 8,
   parameter bit CLAMP_WINDOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [LINE_W-1:0] active_h,
   output logic              vblank,
   output logic              latch_stb,
   output logic              fstart_stb,
   output logic [LINE_W-1:0] line_num
);
   generate
      if (CTRL_GB_LSB + GB_W > REG_W) begin : g_bad_gb
         $error("guardband field does not fit the register width");
      end
      if (LINE_W > REG_W || LINE_W <= GB_W + 1) begin : g_bad_line
         $error("line width out of range");
      end
      if ((1 << ADDR_W) <= ADDR_PUSH) begin : g_bad_addr
         $error("address width too small for the register map");
      end
   endgenerate

   logic [LINE_W-1:0]     vmin_raw, vmax_raw, flip_raw;
   logic                  vrr_on, flip_en, pend, consume;
   logic [CTRL_FSD_W-1:0] fsd_code;
   logic [GB_W-1:0]       guard;
   logic [LINE_W-1:0]     earliest, latest, exit_len;
   logic [LINE_W:0]       fixed_total;

   vrr_regs #(.LINE_W(LINE_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .GB_W(GB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .consume(consume),
      .vmin_raw(vmin_raw), .vmax_raw(vmax_raw), .flip_raw(flip_raw),
      .vrr_on(vrr_on), .flip_en(flip_en), .fsd_code(fsd_code), .guard(guard),
      .pend(pend)
   );

   vrr_window #(.LINE_W(LINE_W), .GB_W(GB_W), .CLAMP(CLAMP_WINDOW)) u_win (
      .clk(clk), .rst_n(rst_n), .vmin_raw(vmin_raw), .vmax_raw(vmax_raw),
      .flip_raw(flip_raw), .flip_en(flip_en), .fsd_code(fsd_code), .guard(guard),
      .earliest(earliest), .latest(latest), .exit_len(exit_len),
      .fixed_total(fixed_total)
   );

   vrr_linegen #(.LINE_W(LINE_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vrr_on(vrr_on), .pend(pend),
      .active_h(active_h), .earliest(earliest), .latest(latest), .exit_len(exit_len),
      .fixed_total(fixed_total), .consume(consume), .line_num(line_num),
      .vblank(vblank), .latch_stb(latch_stb), .fstart_stb(fstart_stb)
   );
endmodule

// File: tb/sim_vrr_vtiming.sv
module sim_vrr_vtiming;
   localparam int PERIOD = 10;
   localparam int LW = 13;
   localparam int RW = 16;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [RW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [RW-1:0] rd_data;
   logic [LW-1:0] active_h = 13'd20;
   logic          vblank, latch_stb, fstart_stb;
   logic [LW-1:0] line_num;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit s_lat, s_fs, s_fs_after;
   int s_line;

   always #(PERIOD/2) clk = ~clk;

   vrr_vtiming u0 (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .active_h(active_h), .vblank(vblank), .latch_stb(latch_stb),
      .fstart_stb(fstart_stb), .line_num(line_num)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = RW'(d);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      rd_addr = AW'(a);
      #1 d = int'(rd_data);
   endtask

   task automatic tick();
      @(negedge clk);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      s_lat = latch_stb; s_fs = fstart_stb; s_line = int'(line_num);
      @(negedge clk);
      s_fs_after = fstart_stb;
   endtask

   task automatic sync();
      for (int i = 0; i < 300; i++) begin
         tick();
         if (s_fs) break;
      end
   endtask

   // push_at: -1 none, 0 before first tick, else after the tick reaching that line
   task automatic measure(input int push_at, output int total, output int lat,
                          output int vb_pre, output int vb_at);
      total = 0; lat = -1; vb_pre = -1; vb_at = -1;
      if (push_at == 0) wr(4, 3);
      for (int i = 0; i < 300; i++) begin
         tick();
         total++;
         if (s_lat) lat = s_line;
         if (s_line == int'(active_h) - 1 && !s_fs) vb_pre = int'(vblank);
         if (s_line == int'(active_h) && !s_fs) vb_at = int'(vblank);
         if (s_fs) break;
         if (push_at > 0 && s_line == push_at) wr(4, 3);
      end
   endtask

   task automatic t_reset();
      int d;
      @(negedge clk);
      chk("R1 line", int'(line_num), 0);
      chk("R1 latch", int'(latch_stb), 0);
      chk("R1 fstart", int'(fstart_stb), 0);
      rd(4, d);
      chk("R1 push", d, 0);
   endtask

   task automatic t_regs();
      int d;
      wr(0, 29); wr(1, 59); wr(2, 30);
      rd(0, d); chk("R2 vmin readback", d, 29);
      rd(1, d); chk("R2 vmax readback", d, 59);
      rd(2, d); chk("R2 flip readback", d, 30);
   endtask

   task automatic t_fixed(input string req);
      int tot, lat, vp, va;
      sync();
      measure(-1, tot, lat, vp, va);
      chk({req, " R2 fixed total"}, tot, 30);
      chk({req, " R3 latch line"}, lat, 20);
      chk("R4 vblank before height", vp, 0);
      chk("R4 vblank at height", va, 1);
      chk("R10 fstart at line 0", s_line, 0);
      chk("R10 fstart one cycle", int'(s_fs_after), 0);
   endtask

   task automatic t_nopush();
      int tot, lat, vp, va;
      wr(3, 'h0507); wr(4, 1);
      sync();
      measure(-1, tot, lat, vp, va);
      chk("R5 latch at vmax-E", lat, 52);
      chk("R5 total vmax", tot, 60);
   endtask

   task automatic t_push_window();
      int tot, lat, vp, va, d;
      sync();
      measure(30, tot, lat, vp, va);
      chk("R6 latch after push", lat, 31);
      chk("R6 total", tot, 39);
      rd(4, d);
      chk("R9 pending cleared", d, 1);
   endtask

   task automatic t_push_early();
      int tot, lat, vp, va, d;
      sync();
      wr(4, 3);
      rd(4, d);
      chk("R9 pending set", d, 3);
      measure(-1, tot, lat, vp, va);
      chk("R7 latch at earliest", lat, 23);
      chk("R7 total flipline", tot, 31);
   endtask

   task automatic t_push_noen();
      int tot, lat, vp, va, d;
      sync();
      wr(4, 2);
      rd(4, d);
      chk("R9 send without enable", d, 0);
      measure(-1, tot, lat, vp, va);
      chk("R9 no early exit", tot, 60);
      wr(4, 1);
   endtask

   task automatic t_flip();
      int tot, lat, vp, va;
      wr(2, 35);
      sync();
      measure(0, tot, lat, vp, va);
      chk("R11 flip on latch", lat, 28);
      chk("R11 flip on total", tot, 36);
      wr(3, 'h0505);
      sync();
      measure(0, tot, lat, vp, va);
      chk("R11 flip off latch", lat, 23);
      chk("R11 flip off total", tot, 31);
   endtask

   task automatic t_exit_len();
      int tot, lat, vp, va;
      wr(3, 'h0A0F);
      sync();
      measure(-1, tot, lat, vp, va);
      chk("R8 long exit latest", lat, 45);
      chk("R8 long exit total", tot, 60);
      sync();
      measure(0, tot, lat, vp, va);
      chk("R8 long exit earliest", lat, 21);
      chk("R8 long exit early total", tot, 36);
   endtask

   task automatic t_disable();
      wr(3, 0); wr(4, 0);
      t_fixed("R12");
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_fixed("R3");
      t_nopush();
      t_push_window();
      t_push_early();
      t_push_noen();
      t_flip();
      t_exit_len();
      t_disable();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule